// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is a behavioural model of a NOR-style parallel flash that obeys the common unlock-based command set. It sits on a simple synchronous bus with a byte address, a 16-bit write word, a write strobe, a read strobe and a registered read word. A small internal array of equal sectors stands in for the flash cells. Program and erase can only be reached through a multi-write unlock handshake, and the decoded command picks one of several read views: the array, the identification words, the query table or the polling status.

Erase does not finish at once. A cycle counter models the erase time, using a separate parameter for a whole-chip erase and for a single-sector erase. For that whole time the `busy` output stays high, writes are discarded, and reads return a polling status word. When the count runs out the device goes back to array reads. An unlock-bypass mode lets a host issue commands with a single write each.

Top module: `pflash_seq_top`

## Requirements
- R1: After reset the device is in array-read mode, `busy` is low, `rd_data` is zero and every array word reads 16'hFFFF.
- R2: A read strobe sampled at a clock edge puts the selected word on `rd_data` after that edge; `rd_data` holds its value in every cycle without a read strobe.
- R3: Command offsets are word offsets (byte address shifted right by one). A command needs 0xAA at word 0x555, then 0x55 at word 0x2AA, then the command byte at word 0x555. A wrong address or data in either unlock write returns the device to array-read mode, and the following writes are not taken as a command.
- R4: Writing 0x98 at word 0x55 from array-read or identification mode enters query mode. A read there returns, in the low byte with the upper byte zero, the table entry indexed by the low eight bits of the word offset: 0x51, 0x52, 0x59 at 0x10 to 0x12, 0x02 at 0x13, log2 of the array size in bytes at 0x27, sector count minus one at 0x2D, sector size in bytes divided by 256 at 0x2F. Index 0x31 and above reads zero.
- R5: Command 0xA0 makes the next write a program: the addressed word becomes the bitwise AND of its old value and the written word.
- R6: A write of 0xF0 or 0xFF returns the device to array-read mode from any state except the write directly after a program command (that value is programmed) and an erase in progress.
- R7: Command 0x80 followed by two more unlock writes arms erase. Then 0x10 at word 0x555 erases the whole array, 0x30 at any word of a sector erases only that sector, and any other final write starts no erase. Erased words read 16'hFFFF and words outside the erased sector are kept.
- R8: `busy` rises after the erase write and stays high for exactly the chip or sector erase cycle count, after which the device is in array-read mode. Writes made while busy have no effect.
- R9: A read while busy returns the polling status: bit 7 is the complement of bit 7 of the erase write (so 16'h0080), every other bit is zero.
- R10: Command 0x90 enters identification mode: low offset byte 0x00 reads the maker code, 0x01 the device code, 0x02 reads zero (sector unprotected).
- R11: Command 0x20 enters unlock bypass, where 0xA0, 0x80 and 0x90 are accepted as single writes at any address. A write of 0x90 followed by 0x00 leaves bypass, after which full unlock writes are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address; bit 0 ignored |
| wr_data | input | 16 | Write word; command byte in bits 7:0 |
| rd_data | output | 16 | Registered read word |
| busy | output | 1 | High while an erase is in progress |

## Verification
The command decoder is tested with correct unlock handshakes, with one that fails on the second address, with commands reached through bypass, and with reset codes sent both in a normal state and as program data. Together these show whether the address, the data byte or the state selects the action. Programs with overlapping bit patterns show AND behaviour rather than overwrite. Sector erase, chip erase and a misaddressed chip erase are timed to the exact cycle and followed by reads inside and outside the erased sector. This separates a correct erase from one that clears too much, clears too little, or ends on the wrong cycle.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    localparam int WOFF_W = 11;

    localparam logic [7:0] CMD_UNL_A     = 8'hAA;
    localparam logic [7:0] CMD_UNL_B     = 8'h55;
    localparam logic [7:0] CMD_PGM       = 8'hA0;
    localparam logic [7:0] CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0] CMD_IDENT     = 8'h90;
    localparam logic [7:0] CMD_BYPASS    = 8'h20;
    localparam logic [7:0] CMD_QUERY     = 8'h98;
    localparam logic [7:0] CMD_RESET     = 8'hF0;
    localparam logic [7:0] CMD_RESET_ALT = 8'hFF;
    localparam logic [7:0] CMD_CHIP      = 8'h10;
    localparam logic [7:0] CMD_SECT      = 8'h30;
    localparam logic [7:0] CMD_BYP_EXIT  = 8'h00;

    localparam logic [WOFF_W-1:0] OFF_UNL_A = 11'h555;
    localparam logic [WOFF_W-1:0] OFF_UNL_B = 11'h2AA;
    localparam logic [WOFF_W-1:0] OFF_QUERY = 11'h055;

    localparam logic [7:0] QTAB_LEN = 8'h31;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_UNL2, S_PGM,
        S_ER_A, S_ER_B, S_ER_C, S_BUSY,
        S_IDENT, S_QRY
    } seq_state_e;

    typedef struct packed {
        logic pgm;
        logic chip;
        logic sect;
    } array_op_t;

    function automatic logic [7:0] qtab_byte(input logic [7:0] idx,
                                             input int unsigned size_log2,
                                             input int unsigned sectors,
                                             input int unsigned sector_bytes);
        logic [31:0] cnt_m1;
        logic [31:0] sb;
        logic [31:0] sl;
        cnt_m1 = sectors - 1;
        sb     = sector_bytes;
        sl     = size_log2;
        case (idx)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h02;
            8'h1B:   return 8'h27;
            8'h1C:   return 8'h36;
            8'h27:   return sl[7:0];
            8'h28:   return 8'h02;
            8'h2C:   return 8'h01;
            8'h2D:   return cnt_m1[7:0];
            8'h2E:   return cnt_m1[15:8];
            8'h2F:   return sb[15:8];
            8'h30:   return sb[23:16];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pflash_array.sv
module pflash_array
    import pflash_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SECTOR_WORDS = 128,
    parameter int SECTORS      = 4,
    localparam int WORDS       = SECTOR_WORDS * SECTORS,
    localparam int IDX_W       = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  array_op_t         op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst || op.chip) begin
            for (int w = 0; w < WORDS; w++) cells[w] <= '1;
        end else if (op.sect) begin
            for (int w = 0; w < WORDS; w++) begin
                if ((w / SECTOR_WORDS) == (int'(idx) / SECTOR_WORDS)) cells[w] <= '1;
            end
        end else if (op.pgm) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    assign rdata = cells[rd_idx];

endmodule

// File: rtl/pflash_erase_timer.sv
module pflash_erase_timer #(
    parameter int CHIP_CYC = 5000,
    parameter int SECT_CYC = 500,
    localparam int MAX_CYC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC,
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_chip,
    input  logic start_sect,
    output logic busy,
    output logic done
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start_chip) begin
            busy   <= 1'b1;
            remain <= CNT_W'(CHIP_CYC - 1);
        end else if (start_sect) begin
            busy   <= 1'b1;
            remain <= CNT_W'(SECT_CYC - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    assign done = busy && (remain == '0);

endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
    import pflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WOFF_W-1:0] woff,
    input  logic [7:0]        cmd,
    input  logic              erase_done,
    output seq_state_e        state,
    output logic              bypass,
    output logic              poll_bit,
    output array_op_t         op
);

    logic at_a, at_b, at_q, is_reset;

    assign at_a     = (woff == OFF_UNL_A);
    assign at_b     = (woff == OFF_UNL_B);
    assign at_q     = (woff == OFF_QUERY);
    assign is_reset = (cmd == CMD_RESET) || (cmd == CMD_RESET_ALT);

    always_comb begin
        op      = '0;
        op.pgm  = wr_en && (state == S_PGM);
        op.chip = wr_en && (state == S_ER_C) && (cmd == CMD_CHIP) && at_a;
        op.sect = wr_en && (state == S_ER_C) && (cmd == CMD_SECT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_READ;
            bypass   <= 1'b0;
            poll_bit <= 1'b0;
        end else if (state == S_BUSY) begin
            if (erase_done) state <= S_READ;
        end else if (wr_en) begin
            if (state != S_PGM && is_reset) begin
                state <= S_READ;
            end else begin
                case (state)
                    S_READ: begin
                        if (at_q && cmd == CMD_QUERY)            state <= S_QRY;
                        else if (bypass && cmd == CMD_PGM)       state <= S_PGM;
                        else if (bypass && cmd == CMD_ERASE_ARM) state <= S_ER_A;
                        else if (bypass && cmd == CMD_IDENT)     state <= S_IDENT;
                        else if (!bypass && at_a && cmd == CMD_UNL_A) state <= S_UNL1;
                    end
                    S_UNL1: state <= (at_b && cmd == CMD_UNL_B) ? S_UNL2 : S_READ;
                    S_UNL2: begin
                        state <= S_READ;
                        if (at_a) begin
                            case (cmd)
                                CMD_PGM:       state  <= S_PGM;
                                CMD_ERASE_ARM: state  <= S_ER_A;
                                CMD_IDENT:     state  <= S_IDENT;
                                CMD_BYPASS:    bypass <= 1'b1;
                                default:       ;
                            endcase
                        end
                    end
                    S_PGM:  state <= S_READ;
                    S_ER_A: state <= (at_a && cmd == CMD_UNL_A) ? S_ER_B : S_READ;
                    S_ER_B: state <= (at_b && cmd == CMD_UNL_B) ? S_ER_C : S_READ;
                    S_ER_C: begin
                        if (op.chip || op.sect) begin
                            state    <= S_BUSY;
                            poll_bit <= ~cmd[7];
                        end else begin
                            state <= S_READ;
                        end
                    end
                    S_IDENT: begin
                        if (bypass && cmd == CMD_BYP_EXIT) begin
                            bypass <= 1'b0;
                            state  <= S_READ;
                        end else if (at_q && cmd == CMD_QUERY) begin
                            state <= S_QRY;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pflash_seq_top.sv
module pflash_seq_top
    import pflash_pkg::*;
#(
    parameter int               DATA_W       = 16,
    parameter int               SECTOR_WORDS = 128,
    parameter int               SECTORS      = 4,
    parameter int               CHIP_CYC     = 5000,
    parameter int               SECT_CYC     = 500,
    parameter logic [15:0]      MAKER_CODE   = 16'h0001,
    parameter logic [15:0]      DEVICE_CODE  = 16'h22C4,
    localparam int              ADDR_W       = WOFF_W + 1,
    localparam int              WORDS        = SECTOR_WORDS * SECTORS,
    localparam int              IDX_W        = $clog2(WORDS),
    localparam int              SIZE_LOG2    = $clog2(WORDS * (DATA_W / 8))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    logic [WOFF_W-1:0] word_off;
    logic              unused_lsb;
    seq_state_e        seq_state;
    logic              bypass_q;
    logic              poll_bit;
    logic              erase_done;
    array_op_t         arr_op;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] rd_next;

    assign word_off   = bus_addr[ADDR_W-1:1];
    assign unused_lsb = bus_addr[0];

    pflash_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .woff       (word_off),
        .cmd        (wr_data[7:0]),
        .erase_done (erase_done),
        .state      (seq_state),
        .bypass     (bypass_q),
        .poll_bit   (poll_bit),
        .op         (arr_op)
    );

    pflash_erase_timer #(
        .CHIP_CYC (CHIP_CYC),
        .SECT_CYC (SECT_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_chip (arr_op.chip),
        .start_sect (arr_op.sect),
        .busy       (busy),
        .done       (erase_done)
    );

    pflash_array #(
        .DATA_W       (DATA_W),
        .SECTOR_WORDS (SECTOR_WORDS),
        .SECTORS      (SECTORS)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .op     (arr_op),
        .idx    (word_off[IDX_W-1:0]),
        .wdata  (wr_data),
        .rd_idx (word_off[IDX_W-1:0]),
        .rdata  (arr_word)
    );

    always_comb begin
        case (seq_state)
            S_QRY: begin
                rd_next = '0;
                if (word_off[7:0] < QTAB_LEN)
                    rd_next = DATA_W'(qtab_byte(word_off[7:0], SIZE_LOG2, SECTORS,
                                                SECTOR_WORDS * (DATA_W / 8)));
            end
            S_IDENT: begin
                case (word_off[7:0])
                    8'h00:   rd_next = DATA_W'(MAKER_CODE);
                    8'h01:   rd_next = DATA_W'(DEVICE_CODE);
                    default: rd_next = '0;
                endcase
            end
            S_BUSY:  rd_next = DATA_W'({poll_bit, 7'b0});
            default: rd_next = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/pflash_seq_chk.sv
module pflash_seq_chk
    import pflash_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WOFF_W-1:0] woff,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input seq_state_e        state,
    input logic              bypass
);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_qtab_tail_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_QRY && rd_en && !wr_en && woff[7:0] >= QTAB_LEN) |=> rd_data == '0);

    p_busy_from_arm_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(state) == S_ER_C);

    p_busy_state_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> state == S_BUSY);

    p_busy_end_read_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> state == S_READ);

    p_poll_word_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) |=> rd_data == DATA_W'(8'h80));

    p_bypass_exit_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(bypass) |-> $past(state) == S_IDENT);

endmodule

bind pflash_seq_top pflash_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .woff    (word_off),
    .rd_data (rd_data),
    .busy    (busy),
    .state   (seq_state),
    .bypass  (bypass_q)
);

// File: tb/tb_pflash_seq_top.sv
module tb_pflash_seq_top;

    localparam int CHIP_CYC = 5000;
    localparam int SECT_CYC = 500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pflash_seq_top #(.CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 16'h0000, 16'hFFFF, 8'd1},   // R1 erased at reset
        '{1'b0, 12'hAAA, 16'h00AA, 16'h0000, 8'd5},   // R5 program 1234
        '{1'b0, 12'h554, 16'h0055, 16'h0000, 8'd5},
        '{1'b0, 12'hAAA, 16'h00A0, 16'h0000, 8'd5},
        '{1'b0, 12'h010, 16'h1234, 16'h0000, 8'd5},
        '{1'b1, 12'h010, 16'h0000, 16'h1234, 8'd5},
        '{1'b0, 12'hAAA, 16'h00AA, 16'h0000, 8'd5},   // R5 AND with FF0F
        '{1'b0, 12'h554, 16'h0055, 16'h0000, 8'd5},
        '{1'b0, 12'hAAA, 16'h00A0, 16'h0000, 8'd5},
        '{1'b0, 12'h010, 16'hFF0F, 16'h0000, 8'd5},
        '{1'b1, 12'h010, 16'h0000, 16'h1204, 8'd5},
        '{1'b0, 12'hAAA, 16'h00AA, 16'h0000, 8'd3},   // R3 bad second address
        '{1'b0, 12'h556, 16'h0055, 16'h0000, 8'd3},
        '{1'b0, 12'hAAA, 16'h00A0, 16'h0000, 8'd3},
        '{1'b0, 12'h010, 16'h0000, 16'h0000, 8'd3},
        '{1'b1, 12'h010, 16'h0000, 16'h1204, 8'd3},
        '{1'b0, 12'hAAA, 16'h00AA, 16'h0000, 8'd10},  // R10 identification
        '{1'b0, 12'h554, 16'h0055, 16'h0000, 8'd10},
        '{1'b0, 12'hAAA, 16'h0090, 16'h0000, 8'd10},
        '{1'b1, 12'h000, 16'h0000, 16'h0001, 8'd10},
        '{1'b1, 12'h002, 16'h0000, 16'h22C4, 8'd10},
        '{1'b1, 12'h004, 16'h0000, 16'h0000, 8'd10},
        '{1'b0, 12'h0AA, 16'h0098, 16'h0000, 8'd4},   // R4 query from ident
        '{1'b1, 12'h020, 16'h0000, 16'h0051, 8'd4},
        '{1'b1, 12'h022, 16'h0000, 16'h0052, 8'd4},
        '{1'b1, 12'h024, 16'h0000, 16'h0059, 8'd4},
        '{1'b1, 12'h04E, 16'h0000, 16'h000A, 8'd4},
        '{1'b1, 12'h05A, 16'h0000, 16'h0003, 8'd4},
        '{1'b1, 12'h05E, 16'h0000, 16'h0001, 8'd4},
        '{1'b1, 12'h062, 16'h0000, 16'h0000, 8'd4},
        '{1'b1, 12'h080, 16'h0000, 16'h0000, 8'd4},
        '{1'b0, 12'h000, 16'h00F0, 16'h0000, 8'd6},   // R6 F0 leaves query
        '{1'b1, 12'h010, 16'h0000, 16'h1204, 8'd6},
        '{1'b0, 12'h0AA, 16'h0098, 16'h0000, 8'd4},   // R4 query from read
        '{1'b1, 12'h026, 16'h0000, 16'h0002, 8'd4},
        '{1'b0, 12'h000, 16'h00FF, 16'h0000, 8'd6},   // R6 FF leaves query
        '{1'b1, 12'h010, 16'h0000, 16'h1204, 8'd6},
        '{1'b0, 12'hAAA, 16'h00AA, 16'h0000, 8'd6},   // R6 F0 as program data
        '{1'b0, 12'h554, 16'h0055, 16'h0000, 8'd6},
        '{1'b0, 12'hAAA, 16'h00A0, 16'h0000, 8'd6},
        '{1'b0, 12'h020, 16'h00F0, 16'h0000, 8'd6},
        '{1'b1, 12'h020, 16'h0000, 16'h00F0, 8'd6},
        '{1'b1, 12'h022, 16'h0000, 16'hFFFF, 8'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [15:0] q);
        rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic unlock();
        do_write(12'hAAA, 16'h00AA);
        do_write(12'h554, 16'h0055);
    endtask

    task automatic erase_arm();
        unlock();
        do_write(12'hAAA, 16'h0080);
        unlock();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] q;
        logic [15:0] held;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset outputs
        check("R1 rd_data", rd_data, 16'h0000);
        check("R1 busy", busy, 1'b0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                do_read(VECS[i].addr, q);
                check($sformatf("R%0d vec %0d", VECS[i].req, i), q, VECS[i].exp);
            end else begin
                do_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R2 read data held without strobe, also across a write
        held = rd_data;
        repeat (3) @(negedge clk);
        check("R2 hold idle", rd_data, held);
        do_write(12'h100, 16'h0000);
        check("R2 hold write", rd_data, held);

        // program a word in sector 1 (word 0x90)
        unlock();
        do_write(12'hAAA, 16'h00A0);
        do_write(12'h120, 16'h5A5A);

        // R7 chip erase at wrong address starts nothing
        erase_arm();
        do_write(12'h000, 16'h0010);
        check("R7 no busy", busy, 1'b0);
        do_read(12'h120, q);
        check("R7 kept", q, 16'h5A5A);

        // R8 sector erase of sector 0 with exact duration
        erase_arm();
        do_write(12'h030, 16'h0030);
        check("R8 busy rise", busy, 1'b1);
        do_read(12'h000, q);
        check("R9 poll word", q, 16'h0080);
        do_write(12'h0AA, 16'h0098);   // R8 write while busy ignored
        n = 2;
        while (busy) begin
            @(negedge clk);
            n++;
        end
        check("R8 sector cycles", n, SECT_CYC);
        do_read(12'h020, q);
        check("R8 ignored write, R7 erased", q, 16'hFFFF);
        do_read(12'h010, q);
        check("R7 sector erased", q, 16'hFFFF);
        do_read(12'h120, q);
        check("R7 other sector kept", q, 16'h5A5A);

        // R8 chip erase duration
        erase_arm();
        do_write(12'hAAA, 16'h0010);
        n = 0;
        while (busy) begin
            @(negedge clk);
            n++;
        end
        check("R8 chip cycles", n, CHIP_CYC);
        do_read(12'h120, q);
        check("R7 chip erased", q, 16'hFFFF);

        // R11 unlock bypass
        unlock();
        do_write(12'hAAA, 16'h0020);
        do_write(12'h000, 16'h00A0);
        do_write(12'h120, 16'h00FF);
        do_read(12'h120, q);
        check("R11 bypass program", q, 16'h00FF);
        do_write(12'h3FE, 16'h00A0);
        do_write(12'h120, 16'h0F0F);
        do_read(12'h120, q);
        check("R11 bypass again", q, 16'h000F);
        do_write(12'h000, 16'h0090);
        do_read(12'h000, q);
        check("R11 bypass ident", q, 16'h0001);
        do_write(12'h000, 16'h0000);
        do_write(12'h000, 16'h00A0);
        do_write(12'h120, 16'h0000);
        do_read(12'h120, q);
        check("R11 bypass left", q, 16'h000F);

        finish_run();
    end

endmodule